// File: doc/BRIEF.md
# Debug Memory Access Command Engine

This block carries out one memory-access command on behalf of a debugger, using the same memory view as the core. A command word arrives with a one-cycle strobe, together with the two argument slots of the debugger's data buffer: the address slot (arg1) and the data slot (arg0). The block decodes the command and checks that the address mode, access size and alignment are supported. If the checks pass, it issues exactly one request on a simple ready/valid memory port.

When the request completes, or when a check rejects the command, the block pulses a done flag with a 3-bit error code. At the same time it presents update strobes for the argument slots. The data slot is refreshed only by a successful read. The address slot is advanced only by a successful access with post-increment enabled. This instance supports physical addressing only, with access sizes from one byte up to one word.

Top module: `dbg_mem_cmd`

## Requirements
- R1: The command word's top byte (bits 31:24) must equal 2. Any other value ends the command with error code 2 and issues no bus request.
- R2: Bit 23 of the command word selects virtual addressing when 1. Virtual mode is unsupported: it gives error code 2 and no bus request. Reserved bits 18:17 and bits 15:0 have no effect.
- R3: Bits 22:20 hold the size code. Codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes above MAX_SIZE (2 by default) give error code 2 with no bus request, and any request carries a size no larger than MAX_SIZE.
- R4: An address in arg1 that is not a multiple of the access size in bytes gives error code 5 and issues no bus request.
- R5: When bit 16 (write) is 0, the block issues a read request at arg1 with the decoded size. On success, arg0_o holds the low size-bits of mem_rdata_i, zero-extended, while arg0_we_o pulses.
- R6: When bit 16 is 1, the block issues a write request. mem_wdata_o carries the low size-bits of arg0 with the upper bits zero, and arg0_we_o stays 0.
- R7: mem_req_o stays high until mem_ready_i is sampled high. While it waits, the address, write enable, size and write data do not change.
- R8: When bit 19 (post-increment) is 1 and the access succeeds, arg1_we_o pulses with arg1_o equal to arg1 plus the size in bytes, wrapping modulo 2^AW. Otherwise arg1_we_o stays 0.
- R9: A bus error (mem_err_i high with mem_ready_i) ends the command with error code 5, and neither update strobe pulses.
- R10: done_o is a one-cycle pulse. It occurs in the cycle after mem_ready_i is accepted, or in the cycle after the strobe when a check rejects the command. err_o is valid with done_o and reads 0 otherwise.
- R11: After reset, done_o, mem_req_o, both update strobes and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, honoured when idle |
| cmd_i | input | 32 | Command word |
| arg0_i | input | DW | Data slot of the data buffer |
| arg1_i | input | AW | Address slot of the data buffer |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| err_o | output | 3 | Error code: 0 ok, 2 unsupported, 5 access failure |
| arg0_we_o | output | 1 | Load arg0_o into the data slot |
| arg0_o | output | DW | Read result |
| arg1_we_o | output | 1 | Load arg1_o into the address slot |
| arg1_o | output | AW | Incremented address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_size_o | output | 3 | Access size code |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data, right-justified |
| mem_ready_i | input | 1 | Request accepted and completed |
| mem_rdata_i | input | DW | Read data, right-justified |
| mem_err_i | input | 1 | Access error, qualified by mem_ready_i |

## Verification
A stale latched size would show up as wrong masking on mem_wdata_o or arg0_o, or as a wrong arg1_o step. These become visible in the request cycle or the completion cycle of the same command. A state machine stuck in the wait state shows as mem_req_o staying high, or as done_o never arriving after the ready handshake; the cycle-exact comparison catches either at the first cycle of divergence. A mis-decoded check shows as an unexpected request in the cycle after the strobe, or as a wrong error code on done_o.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
  localparam logic [7:0] CMDTYPE_MEM = 8'd2;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_NOSUP = 3'd2,
    ERR_ACC   = 3'd5
  } err_e;

  typedef struct packed {
    logic [7:0]  ctype;
    logic        virt;
    logic [2:0]  size;
    logic        postinc;
    logic [1:0]  rsvd;
    logic        write;
    logic [15:0] tgt;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_RESP
  } st_e;
endpackage

// File: rtl/dbg_mem_decode.sv
module dbg_mem_decode
  import dbg_mem_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned MAX_SIZE = 2
) (
  input  cmd_t           cmd_i,
  input  logic [AW-1:0]  addr_i,
  output err_e           err_o,
  output logic [4:0]     nbytes_o
);
  localparam logic [2:0] MAX_SZ = 3'(MAX_SIZE);

  logic [AW-1:0] lsb_mask;

  always_comb begin
    nbytes_o = 5'd1 << cmd_i.size;
    lsb_mask = AW'(nbytes_o) - AW'(1);
    if (cmd_i.ctype != CMDTYPE_MEM || cmd_i.virt || cmd_i.size > MAX_SZ)
      err_o = ERR_NOSUP;
    else if ((addr_i & lsb_mask) != '0)
      err_o = ERR_ACC;
    else
      err_o = ERR_NONE;
  end
endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dbg_mem_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned MAX_SIZE = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  cmd_t           cmd_i,
  input  logic [DW-1:0]  arg0_i,
  input  logic [AW-1:0]  arg1_i,
  input  err_e           chk_err_i,
  input  logic [4:0]     nbytes_i,
  output logic           done_o,
  output err_e           err_o,
  output logic           arg0_we_o,
  output logic [DW-1:0]  arg0_o,
  output logic           arg1_we_o,
  output logic [AW-1:0]  arg1_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [2:0]     mem_size_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_err_i
);
  localparam int unsigned NLANE  = DW / 8;
  localparam logic [2:0]  MAX_SZ = 3'(MAX_SIZE);

  st_e           st_q;
  logic          write_q, postinc_q;
  logic [2:0]    size_q;
  logic [4:0]    nbytes_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  err_e          err_q;
  logic [DW-1:0] lane_mask;
  logic          ok;

  // byte lanes enabled below the access size
  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{5'(b) < nbytes_q}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      write_q   <= 1'b0;
      postinc_q <= 1'b0;
      size_q    <= '0;
      nbytes_q  <= 5'd1;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      err_q     <= ERR_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          write_q   <= cmd_i.write;
          postinc_q <= cmd_i.postinc;
          size_q    <= cmd_i.size;
          nbytes_q  <= nbytes_i;
          addr_q    <= arg1_i;
          wdata_q   <= arg0_i;
          err_q     <= chk_err_i;
          st_q      <= (chk_err_i == ERR_NONE) ? ST_BUS : ST_RESP;
        end
        ST_BUS: if (mem_ready_i) begin
          rdata_q <= mem_rdata_i;
          err_q   <= mem_err_i ? ERR_ACC : ERR_NONE;
          st_q    <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_BUS);
  assign mem_we_o    = mem_req_o & write_q;
  assign mem_size_o  = size_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q & lane_mask;

  assign done_o    = (st_q == ST_RESP);
  assign err_o     = done_o ? err_q : ERR_NONE;
  assign ok        = done_o & (err_q == ERR_NONE);
  assign arg0_we_o = ok & ~write_q;
  assign arg0_o    = rdata_q & lane_mask;
  assign arg1_we_o = ok & postinc_q;
  assign arg1_o    = addr_q + AW'(nbytes_q);

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o) && $stable(mem_size_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  size_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_size_o <= MAX_SZ);
  // R4
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o & (AW'(nbytes_q) - AW'(1))) == '0);
  // R9
  bus_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && mem_err_i |=>
      done_o && err_o == ERR_ACC && !arg0_we_o && !arg1_we_o);
  // R8
  arg1_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arg1_we_o |-> done_o && err_o == ERR_NONE);
endmodule

// File: rtl/dbg_mem_cmd.sv
module dbg_mem_cmd
  import dbg_mem_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned MAX_SIZE = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [31:0]    cmd_i,
  input  logic [DW-1:0]  arg0_i,
  input  logic [AW-1:0]  arg1_i,
  output logic           done_o,
  output logic [2:0]     err_o,
  output logic           arg0_we_o,
  output logic [DW-1:0]  arg0_o,
  output logic           arg1_we_o,
  output logic [AW-1:0]  arg1_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [2:0]     mem_size_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_err_i
);
  cmd_t       cmd;
  err_e       chk_err, seq_err;
  logic [4:0] nbytes;

  assign cmd   = cmd_t'(cmd_i);
  assign err_o = seq_err;

  dbg_mem_decode #(.AW(AW), .MAX_SIZE(MAX_SIZE)) i_decode (
    .cmd_i    (cmd),
    .addr_i   (arg1_i),
    .err_o    (chk_err),
    .nbytes_o (nbytes)
  );

  dbg_mem_seq #(.AW(AW), .DW(DW), .MAX_SIZE(MAX_SIZE)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_valid_i),
    .cmd_i       (cmd),
    .arg0_i      (arg0_i),
    .arg1_i      (arg1_i),
    .chk_err_i   (chk_err),
    .nbytes_i    (nbytes),
    .done_o      (done_o),
    .err_o       (seq_err),
    .arg0_we_o   (arg0_we_o),
    .arg0_o      (arg0_o),
    .arg1_we_o   (arg1_we_o),
    .arg1_o      (arg1_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_size_o  (mem_size_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_err_i   (mem_err_i)
  );
endmodule

// File: tb/test_dbg_mem_cmd.sv
module test_dbg_mem_cmd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_i = '0, arg0_i = '0, arg1_i = '0;
  logic        done_o, arg0_we_o, arg1_we_o, mem_req_o, mem_we_o;
  logic [2:0]  err_o, mem_size_o;
  logic [31:0] arg0_o, arg1_o, mem_addr_o, mem_wdata_o;
  logic        mem_ready_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int vectors = 0, errors = 0;
  logic [7:0] mem [64];

  always #10 clk_i = ~clk_i;

  dbg_mem_cmd i_dbg_mem_cmd (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] ct, input bit virt, input logic [2:0] sz,
                                     input bit pinc, input bit wr, input logic [15:0] tgt);
    return {ct, virt, sz, pinc, 2'b11, wr, tgt};
  endfunction

  function automatic logic [31:0] mask_of(input int nb);
    return (nb >= 4) ? 32'hffff_ffff : ((32'h1 << (nb * 8)) - 1);
  endfunction

  task automatic run(input logic [31:0] cmd, input logic [31:0] a0, input logic [31:0] a1,
                     input int lat, input bit berr);
    int sz = int'(cmd[22:20]);
    int nb = 1 << sz;
    bit wr = cmd[16], pinc = cmd[19];
    int exp_err;
    logic [31:0] word, m;
    if (cmd[31:24] != 8'd2 || cmd[23] || sz > 2) exp_err = 2;
    else if (a1 % nb != 0) exp_err = 5;
    else exp_err = 0;
    m = mask_of(nb);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = cmd; arg0_i = a0; arg1_i = a1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; arg0_i = $urandom; arg1_i = $urandom;
    if (exp_err != 0) begin
      // R1 R2 R3 R4 rejection before the bus
      chk(done_o === 1'b1, "R10 done after reject", 32'(done_o), 1);
      chk(err_o === 3'(exp_err), "R1/R2/R3/R4 err code", 32'(err_o), 32'(exp_err));
      chk(mem_req_o === 1'b0, "R4 no request on reject", 32'(mem_req_o), 0);
      chk(!arg0_we_o && !arg1_we_o, "R8 no update on reject", {arg0_we_o, arg1_we_o}, 0);
    end else begin
      for (int k = 0; k <= lat; k++) begin
        chk(mem_req_o === 1'b1 && done_o === 1'b0, "R7 request held", 32'(mem_req_o), 1);
        chk(mem_addr_o === a1, "R5 request address", mem_addr_o, a1);
        chk(mem_we_o === wr && mem_size_o === 3'(sz), "R5/R6 we and size",
            {mem_we_o, mem_size_o}, {wr, 3'(sz)});
        if (wr) chk(mem_wdata_o === (a0 & m), "R6 write data masked", mem_wdata_o, a0 & m);
        if (k == lat) begin
          word = {mem[(a1 + 3) & 63], mem[(a1 + 2) & 63], mem[(a1 + 1) & 63], mem[a1 & 63]};
          mem_ready_i = 1'b1; mem_err_i = berr; mem_rdata_i = word;
          if (wr && !berr)
            for (int b = 0; b < nb; b++) mem[(a1 + b) & 63] = a0[b*8 +: 8];
        end
        @(negedge clk_i);
      end
      mem_ready_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = $urandom;
      chk(done_o === 1'b1, "R10 done after ready", 32'(done_o), 1);
      chk(err_o === (berr ? 3'd5 : 3'd0), "R9 completion err", 32'(err_o), berr ? 5 : 0);
      chk(mem_req_o === 1'b0, "R7 request dropped", 32'(mem_req_o), 0);
      chk(arg0_we_o === (!wr && !berr), "R5/R6 arg0 update", 32'(arg0_we_o), 32'(!wr && !berr));
      if (!wr && !berr) chk(arg0_o === (word & m), "R5 read data", arg0_o, word & m);
      chk(arg1_we_o === (pinc && !berr), "R8 arg1 update", 32'(arg1_we_o), 32'(pinc && !berr));
      if (pinc && !berr) chk(arg1_o === a1 + 32'(nb), "R8 incremented addr", arg1_o, a1 + 32'(nb));
    end
    @(negedge clk_i);
    chk(done_o === 1'b0 && err_o === 3'd0, "R10 single pulse", {done_o, err_o}, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk_i);
    // R11
    chk(!done_o && !mem_req_o && !arg0_we_o && !arg1_we_o && err_o == 0, "R11 reset state",
        {done_o, mem_req_o, arg0_we_o, arg1_we_o, err_o}, 0);
    rst_ni = 1'b1;
    run(mk(2, 0, 2, 0, 0, 0), 0, 32'h8, 0, 0);                    // R5 word read
    run(mk(2, 0, 0, 1, 0, 0), 0, 32'h5, 2, 0);                    // R5 R8 byte
    run(mk(2, 0, 1, 1, 0, 16'hbeef), 0, 32'h6, 1, 0);             // R2 target bits ignored
    run(mk(2, 0, 0, 1, 1, 0), 32'haabbccdd, 32'h3, 1, 0);         // R6 byte write
    run(mk(2, 0, 2, 0, 1, 0), 32'h1234_5678, 32'hc, 3, 0);        // R6 word write
    run(mk(2, 0, 2, 0, 0, 0), 0, 32'hc, 0, 0);                    // read back
    run(mk(2, 0, 1, 1, 1, 0), 32'h5555_9876, 32'h20, 2, 0);       // R6 half write
    run(mk(2, 0, 1, 0, 0, 0), 0, 32'h7, 0, 0);                    // R4 misaligned half
    run(mk(2, 0, 2, 1, 0, 0), 0, 32'h2, 0, 0);                    // R4 misaligned word
    run(mk(2, 0, 3, 0, 0, 0), 0, 32'h8, 0, 0);                    // R3 size 3
    run(mk(2, 0, 4, 1, 1, 0), 0, 32'h10, 0, 0);                   // R3 size 4
    run(mk(2, 1, 2, 0, 0, 0), 0, 32'h8, 0, 0);                    // R2 virtual
    run(mk(0, 0, 2, 0, 0, 0), 0, 32'h8, 0, 0);                    // R1 other type
    run(mk(3, 0, 0, 1, 1, 0), 0, 32'h1, 0, 0);                    // R1 other type
    run(mk(2, 0, 2, 1, 0, 0), 0, 32'h10, 1, 1);                   // R9 read error
    run(mk(2, 0, 0, 1, 1, 0), 32'hff, 32'h11, 2, 1);              // R9 write error
    run(mk(2, 0, 2, 1, 0, 0), 0, 32'hffff_fffc, 1, 0);            // R8 wrap
    run(mk(2, 0, 0, 0, 0, 0), 0, 32'h3, 0, 0);                    // R6 byte landed
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule